// File: doc/BRIEF.md
# Modal Fourier Coefficient Unit

This block sits between the forward two-dimensional transforms of the x and y slope maps and the inverse transform that rebuilds the wavefront phase. Each clock it can accept one frequency bin from both slope spectra, together with the row and column frequency indices of that bin. Both spectra are multiplied by a purely imaginary spatial filter factor. The two products are added, and the complex result is rounded down to the sample width that the inverse transform expects.

The factor for the x spectrum at signed frequencies (p, q) is j·p/(p²+q²), and the factor for the y spectrum is j·q/(p²+q²). The y matrix is the transpose of the x matrix, so a single constant table serves both paths. The x path reads it at (row, col) and the y path reads it at (col, row). The table keeps real and imaginary parts as separate constant arrays. The unit is fully pipelined: a new bin may enter every cycle, and gaps in the valid stream are carried through unchanged.

Top module: `mfc_coef_unit`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly 8 clock cycles, and each output sample belongs to the input sample accepted 8 cycles earlier.
- R2: Each of the four spectrum inputs (IN_W = 22 bits) is rounded to 18 bits by discarding its 4 least significant bits with round-half-away-from-zero, then saturated to ±131071.
- R3: The imaginary table entry at (r, c) is round-half-away(16384·sr/(sr²+sc²)), where sk = k for k < N/2 and k − N otherwise (N = 8). The entry at (0, 0) is 0, and every real table entry is 0.
- R4: The x spectrum is multiplied by the table value read at (row = `in_row`, col = `in_col`).
- R5: The y spectrum is multiplied by the table value read at the transposed address (row = `in_col`, col = `in_row`).
- R6: Each complex product is exact: real = ar·br − ai·bi, imaginary = ar·bi + ai·br.
- R7: The two complex products are summed without loss. Zero spectra give a zero output.
- R8: The sum is divided by 2^14 with round-half-away-from-zero and saturated symmetrically to ±32767. The value −32768 never appears on an output.
- R9: A bin at row 0, col 0 gives a zero output, whatever the spectrum values.
- R10: While `rst_n` is low at a clock edge, the next state has `out_valid` = 0 and both outputs at zero.
- R11: Back-to-back bins on consecutive cycles and bins with idle gaps between them are all processed, each independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input bin is present this cycle |
| in_row | input | LOG2N | Row frequency index of the bin |
| in_col | input | LOG2N | Column frequency index of the bin |
| sx_re | input | IN_W | x-slope spectrum, real part |
| sx_im | input | IN_W | x-slope spectrum, imaginary part |
| sy_re | input | IN_W | y-slope spectrum, real part |
| sy_im | input | IN_W | y-slope spectrum, imaginary part |
| out_valid | output | 1 | Output coefficient is present |
| out_re | output | OUT_W | Coefficient, real part |
| out_im | output | OUT_W | Coefficient, imaginary part |

## Verification
A table entry that is wrong, or an address that is not transposed on the y path, shows as a wrong coefficient at the ports exactly 8 cycles after the affected bin. The x-only and y-only sweeps over all 64 bins isolate such an error to a single path and a single index. A valid bit or index that falls out of step with the data shifts every coefficient onto its neighbour, so the first mismatch appears on the first bin that follows. Rounding or saturation faults surface on the tie and full-scale stimuli, also 8 cycles after entry.

// File: rtl/mfc_pkg.sv
// Package: shared constants and the constant function that fills the
// filter factor table. Assumes N is a power of two and frac < 62.
package mfc_pkg;

    localparam int IN_STAGES  = 2;  // input rounding + table read
    localparam int MUL_STAGES = 4;  // complex multiplier
    localparam int ADD_STAGES = 1;  // complex adder
    localparam int OUT_STAGES = 1;  // output rounding
    localparam int PIPE_LAT   = IN_STAGES + MUL_STAGES + ADD_STAGES + OUT_STAGES;

    // Map an unsigned transform index to its signed frequency.
    function automatic int signed_freq(input int k, input int n);
        if (k < n / 2) return k;
        return k - n;
    endfunction

    // Imaginary factor p/(p^2+q^2) scaled by 2^frac, rounded half away
    // from zero and clamped to a cw-bit symmetric range.
    function automatic longint factor_val(input int r, input int c, input int n,
                                          input int frac, input int cw);
        int     p;
        int     q;
        longint d;
        longint num;
        longint mag;
        longint lim;
        p = signed_freq(r, n);
        q = signed_freq(c, n);
        d = longint'(p * p + q * q);
        if (d == 0) return 0;
        num = longint'(p) <<< frac;
        if (num < 0) mag = ((-num) * 2 + d) / (2 * d);
        else         mag = (num * 2 + d) / (2 * d);
        lim = (longint'(1) <<< (cw - 1)) - 1;
        if (mag > lim) mag = lim;
        if (num < 0) return -mag;
        return mag;
    endfunction

endpackage

// File: rtl/mfc_round.sv
// Registered rounder: drops SHIFT low bits of a signed value with round
// half away from zero, then clamps to +/-(2^(OW-1)-1).
// Assumes IW >= OW and IW - SHIFT >= 1.
module mfc_round #(
    parameter int IW    = 22,
    parameter int OW    = 18,
    parameter int SHIFT = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [IW-1:0] din,
    output logic signed [OW-1:0] dout
);
    localparam int EW = IW + 1;
    localparam logic signed [EW-1:0] HALF  = EW'((64'd1 << SHIFT) >> 1);
    localparam logic signed [EW-1:0] NBIAS = (SHIFT > 0) ? HALF - EW'(1) : EW'(0);
    localparam logic signed [EW-1:0] MAXV  = EW'((64'd1 << (OW - 1)) - 64'd1);

    logic signed [EW-1:0] ext;
    logic signed [EW-1:0] biased;
    logic signed [EW-1:0] shifted;
    logic signed [EW-1:0] clamped;

    // Bias toward zero-symmetric rounding, shift, then clamp.
    always_comb begin
        ext     = EW'(din);
        biased  = din[IW-1] ? (ext + NBIAS) : (ext + HALF);
        shifted = biased >>> SHIFT;
        if (shifted > MAXV)       clamped = MAXV;
        else if (shifted < -MAXV) clamped = -MAXV;
        else                      clamped = shifted;
    end

    // Register the rounded result.
    always_ff @(posedge clk) begin
        if (!rst_n) dout <= '0;
        else        dout <= OW'(clamped);
    end
endmodule

// File: rtl/mfc_factor_rom.sv
// Constant filter factor table with PORTS registered read ports.
// The real and imaginary parts are kept as separate arrays. Contents
// are computed at elaboration from mfc_pkg::factor_val.
module mfc_factor_rom #(
    parameter int LOG2N     = 3,
    parameter int COEF_W    = 16,
    parameter int COEF_FRAC = 14,
    parameter int PORTS     = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [PORTS-1:0][LOG2N-1:0]        rd_row,
    input  logic [PORTS-1:0][LOG2N-1:0]        rd_col,
    output logic [PORTS-1:0][COEF_W-1:0]       rd_re,
    output logic [PORTS-1:0][COEF_W-1:0]       rd_im
);
    localparam int N     = 1 << LOG2N;
    localparam int DEPTH = N * N;

    logic [COEF_W-1:0] tab_re [DEPTH];
    logic [COEF_W-1:0] tab_im [DEPTH];

    // Fill both tables with constants.
    for (genvar e = 0; e < DEPTH; e++) begin : g_fill
        assign tab_re[e] = '0;
        assign tab_im[e] = COEF_W'(mfc_pkg::factor_val(e / N, e % N, N, COEF_FRAC, COEF_W));
    end

    // One registered lookup per port.
    for (genvar k = 0; k < PORTS; k++) begin : g_port
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_re[k] <= '0;
                rd_im[k] <= '0;
            end else begin
                rd_re[k] <= tab_re[{rd_row[k], rd_col[k]}];
                rd_im[k] <= tab_im[{rd_row[k], rd_col[k]}];
            end
        end
    end
endmodule

// File: rtl/mfc_cmul.sv
// Four-stage pipelined complex multiplier built from four real products.
// Stage 1 registers the operands, stage 2 the products, stage 3 re-times
// the products, and stage 4 forms re = rr - ii and im = ri + ir.
// Full precision, no rounding.
module mfc_cmul #(
    parameter int AW = 18,
    parameter int BW = 16,
    localparam int PW = AW + BW,
    localparam int YW = PW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [AW-1:0] a_re,
    input  logic signed [AW-1:0] a_im,
    input  logic signed [BW-1:0] b_re,
    input  logic signed [BW-1:0] b_im,
    output logic signed [YW-1:0] y_re,
    output logic signed [YW-1:0] y_im
);
    logic signed [AW-1:0] ar_q, ai_q;
    logic signed [BW-1:0] br_q, bi_q;
    logic signed [PW-1:0] p_rr, p_ii, p_ri, p_ir;
    logic signed [PW-1:0] q_rr, q_ii, q_ri, q_ir;

    // Stage 1: capture the operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ar_q <= '0; ai_q <= '0; br_q <= '0; bi_q <= '0;
        end else begin
            ar_q <= a_re; ai_q <= a_im; br_q <= b_re; bi_q <= b_im;
        end
    end

    // Stage 2: four real products.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_rr <= '0; p_ii <= '0; p_ri <= '0; p_ir <= '0;
        end else begin
            p_rr <= PW'(ar_q) * PW'(br_q);
            p_ii <= PW'(ai_q) * PW'(bi_q);
            p_ri <= PW'(ar_q) * PW'(bi_q);
            p_ir <= PW'(ai_q) * PW'(br_q);
        end
    end

    // Stage 3: re-time the products ahead of the add/subtract.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_rr <= '0; q_ii <= '0; q_ri <= '0; q_ir <= '0;
        end else begin
            q_rr <= p_rr; q_ii <= p_ii; q_ri <= p_ri; q_ir <= p_ir;
        end
    end

    // Stage 4: subtract for the real part, add for the imaginary part.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_re <= '0; y_im <= '0;
        end else begin
            y_re <= YW'(q_rr) - YW'(q_ii);
            y_im <= YW'(q_ri) + YW'(q_ir);
        end
    end
endmodule

// File: rtl/mfc_coef_unit.sv
// Modal Fourier coefficient unit. Rounds two input spectra to MUL_W bits,
// looks up the shared filter factor (x at row/col, y at col/row),
// multiplies each spectrum by its factor, adds the two products and
// rounds the sum to OUT_W bits. Fixed latency of mfc_pkg::PIPE_LAT
// cycles. A valid bit travels with the data. Assumes IN_W >= MUL_W.
module mfc_coef_unit #(
    parameter int LOG2N     = 3,
    parameter int IN_W      = 22,
    parameter int MUL_W     = 18,
    parameter int COEF_W    = 16,
    parameter int COEF_FRAC = 14,
    parameter int OUT_W     = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [LOG2N-1:0]        in_row,
    input  logic [LOG2N-1:0]        in_col,
    input  logic signed [IN_W-1:0]  sx_re,
    input  logic signed [IN_W-1:0]  sx_im,
    input  logic signed [IN_W-1:0]  sy_re,
    input  logic signed [IN_W-1:0]  sy_im,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_re,
    output logic signed [OUT_W-1:0] out_im
);
    localparam int LAT    = mfc_pkg::PIPE_LAT;
    localparam int LANES  = 4;
    localparam int PATHS  = 2;
    localparam int IN_SH  = IN_W - MUL_W;
    localparam int PROD_W = MUL_W + COEF_W + 1;
    localparam int SUM_W  = PROD_W + 1;

    logic signed [IN_W-1:0]  lane_in  [LANES];
    logic signed [MUL_W-1:0] lane_rnd [LANES];
    logic signed [MUL_W-1:0] lane_d   [LANES];
    logic [LOG2N-1:0]        row_q, col_q;
    logic [PATHS-1:0][LOG2N-1:0]  rom_row, rom_col;
    logic [PATHS-1:0][COEF_W-1:0] rom_re, rom_im;
    logic signed [PROD_W-1:0] prod_re [PATHS];
    logic signed [PROD_W-1:0] prod_im [PATHS];
    logic signed [SUM_W-1:0]  sum_re, sum_im;
    logic [LAT-1:0]           vpipe;

    assign lane_in[0] = sx_re;
    assign lane_in[1] = sx_im;
    assign lane_in[2] = sy_re;
    assign lane_in[3] = sy_im;

    // Input rounding, one rounder per spectrum component.
    for (genvar l = 0; l < LANES; l++) begin : g_in_rnd
        mfc_round #(.IW(IN_W), .OW(MUL_W), .SHIFT(IN_SH)) u_rnd (
            .clk(clk), .rst_n(rst_n), .din(lane_in[l]), .dout(lane_rnd[l])
        );
    end

    // Capture the indices alongside the rounded data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
        end else begin
            row_q <= in_row;
            col_q <= in_col;
        end
    end

    // Delay the rounded data one cycle to line it up with the table read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l < LANES; l++) lane_d[l] <= '0;
        end else begin
            for (int l = 0; l < LANES; l++) lane_d[l] <= lane_rnd[l];
        end
    end

    // Port 0 serves the x path, port 1 the y path at the transposed address.
    assign rom_row[0] = row_q;
    assign rom_col[0] = col_q;
    assign rom_row[1] = col_q;
    assign rom_col[1] = row_q;

    mfc_factor_rom #(
        .LOG2N(LOG2N), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC), .PORTS(PATHS)
    ) u_rom (
        .clk(clk), .rst_n(rst_n),
        .rd_row(rom_row), .rd_col(rom_col),
        .rd_re(rom_re), .rd_im(rom_im)
    );

    // One complex multiplier per gradient path.
    for (genvar g = 0; g < PATHS; g++) begin : g_path
        mfc_cmul #(.AW(MUL_W), .BW(COEF_W)) u_cmul (
            .clk(clk), .rst_n(rst_n),
            .a_re(lane_d[2*g]), .a_im(lane_d[2*g+1]),
            .b_re(signed'(rom_re[g])), .b_im(signed'(rom_im[g])),
            .y_re(prod_re[g]), .y_im(prod_im[g])
        );
    end

    // Complex adder: real and imaginary sums in parallel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_re <= '0;
            sum_im <= '0;
        end else begin
            sum_re <= SUM_W'(prod_re[0]) + SUM_W'(prod_re[1]);
            sum_im <= SUM_W'(prod_im[0]) + SUM_W'(prod_im[1]);
        end
    end

    // Output rounding to the width of the following inverse transform.
    mfc_round #(.IW(SUM_W), .OW(OUT_W), .SHIFT(COEF_FRAC)) u_out_re (
        .clk(clk), .rst_n(rst_n), .din(sum_re), .dout(out_re)
    );
    mfc_round #(.IW(SUM_W), .OW(OUT_W), .SHIFT(COEF_FRAC)) u_out_im (
        .clk(clk), .rst_n(rst_n), .din(sum_im), .dout(out_im)
    );

    // Valid bit shifted along with the data.
    always_ff @(posedge clk) begin
        if (!rst_n) vpipe <= '0;
        else        vpipe <= {vpipe[LAT-2:0], in_valid};
    end

    assign out_valid = vpipe[LAT-1];
endmodule

// File: rtl/mfc_coef_unit_chk.sv
// Checker for mfc_coef_unit: tracks, at the ports, which input bins were
// valid, which sat at the DC index and which had all-zero spectra, then
// checks what the outputs show PIPE_LAT cycles later.
module mfc_coef_unit_chk #(
    parameter int LOG2N = 3,
    parameter int IN_W  = 22,
    parameter int OUT_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic [LOG2N-1:0]        in_row,
    input logic [LOG2N-1:0]        in_col,
    input logic signed [IN_W-1:0]  sx_re,
    input logic signed [IN_W-1:0]  sx_im,
    input logic signed [IN_W-1:0]  sy_re,
    input logic signed [IN_W-1:0]  sy_im,
    input logic                    out_valid,
    input logic signed [OUT_W-1:0] out_re,
    input logic signed [OUT_W-1:0] out_im
);
    localparam int LAT = mfc_pkg::PIPE_LAT;
    localparam logic signed [OUT_W-1:0] MINV = {1'b1, {(OUT_W-1){1'b0}}};

    logic [LAT-1:0] seen_v, seen_dc, seen_zero;

    // History of input properties, one bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_v    <= '0;
            seen_dc   <= '0;
            seen_zero <= '0;
        end else begin
            seen_v    <= {seen_v[LAT-2:0], in_valid};
            seen_dc   <= {seen_dc[LAT-2:0], in_valid && in_row == '0 && in_col == '0};
            seen_zero <= {seen_zero[LAT-2:0],
                          in_valid && sx_re == '0 && sx_im == '0 && sy_re == '0 && sy_im == '0};
        end
    end

    a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == seen_v[LAT-1]);

    a_r9_dc_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && seen_dc[LAT-1]) |-> (out_re == '0 && out_im == '0));

    a_r7_zero_in_zero_out: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && seen_zero[LAT-1]) |-> (out_re == '0 && out_im == '0));

    a_r8_symmetric_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_re != MINV && out_im != MINV));
endmodule

bind mfc_coef_unit mfc_coef_unit_chk #(
    .LOG2N(LOG2N), .IN_W(IN_W), .OUT_W(OUT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_row(in_row), .in_col(in_col),
    .sx_re(sx_re), .sx_im(sx_im), .sy_re(sy_re), .sy_im(sy_im),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
);

// File: tb/mfc_coef_unit_bench.sv
// Bench: behavioural reference with a queue of expected outputs,
// compared every clock at the falling edge.
module mfc_coef_unit_bench;
    localparam int LOG2N = 3;
    localparam int N     = 1 << LOG2N;
    localparam int IN_W  = 22;
    localparam int OUT_W = 16;
    localparam int LAT   = 8;

    typedef struct {
        bit     v;
        longint re;
        longint im;
        string  tag;
    } exp_t;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_valid = 1'b0;
    logic [LOG2N-1:0]        in_row = '0;
    logic [LOG2N-1:0]        in_col = '0;
    logic signed [IN_W-1:0]  sx_re = '0, sx_im = '0, sy_re = '0, sy_im = '0;
    logic                    out_valid;
    logic signed [OUT_W-1:0] out_re, out_im;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t q[$];

    always #10 clk = ~clk;

    mfc_coef_unit u_mfc_coef_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_row(in_row), .in_col(in_col),
        .sx_re(sx_re), .sx_im(sx_im), .sy_re(sy_re), .sy_im(sy_im),
        .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
    );

    // Divide by 2^s rounding half away from zero, then clamp to +/-(2^(w-1)-1).
    function automatic longint rsat(input longint x, input int s, input int w);
        longint h, r, m;
        h = (s > 0) ? (longint'(1) <<< (s - 1)) : 0;
        if (s == 0)      r = x;
        else if (x >= 0) r = (x + h) >>> s;
        else             r = -(((-x) + h) >>> s);
        m = (longint'(1) <<< (w - 1)) - 1;
        if (r > m)  r = m;
        if (r < -m) r = -m;
        return r;
    endfunction

    function automatic longint sfq(input int k);
        return (k < N / 2) ? longint'(k) : longint'(k - N);
    endfunction

    // Table value from the formula in R3.
    function automatic longint tabv(input int r, input int c);
        longint p, qq, d, num;
        p = sfq(r); qq = sfq(c);
        d = p * p + qq * qq;
        if (d == 0) return 0;
        num = p * 16384;
        if (num >= 0) return (2 * num + d) / (2 * d);
        return -((2 * (-num) + d) / (2 * d));
    endfunction

    task automatic check_val(input string tag, input string what, input longint got, input longint want);
        checks++;
        if (got != want) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, want);
        end
    endtask

    // One clock: compare the oldest expectation, then apply a new input.
    task automatic step(input bit v, input int r, input int c,
                        input longint xr, input longint xi,
                        input longint yr, input longint yi, input string tag);
        exp_t   e, f;
        longint axr, axi, ayr, ayi, cx, cy;
        @(negedge clk);
        if (q.size() >= LAT) begin
            f = q.pop_front();
            check_val("R1", "out_valid", longint'(out_valid), longint'(f.v));
            if (f.v) begin
                check_val(f.tag, "out_re", longint'(out_re), f.re);
                check_val(f.tag, "out_im", longint'(out_im), f.im);
            end
        end
        in_valid = v;
        in_row = LOG2N'(r);
        in_col = LOG2N'(c);
        sx_re = IN_W'(xr); sx_im = IN_W'(xi);
        sy_re = IN_W'(yr); sy_im = IN_W'(yi);
        axr = rsat(longint'(sx_re), 4, 18);
        axi = rsat(longint'(sx_im), 4, 18);
        ayr = rsat(longint'(sy_re), 4, 18);
        ayi = rsat(longint'(sy_im), 4, 18);
        cx = tabv(r, c);          // R4: x path at (row, col)
        cy = tabv(c, r);          // R5: y path at (col, row)
        e.v   = v;
        e.re  = rsat(-(axi * cx) - (ayi * cy), 14, 16);
        e.im  = rsat((axr * cx) + (ayr * cy), 14, 16);
        e.tag = tag;
        q.push_back(e);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        exp_t idle;
        // R10: reset state
        repeat (4) @(negedge clk);
        check_val("R10", "out_valid in reset", longint'(out_valid), 0);
        check_val("R10", "out_re in reset", longint'(out_re), 0);
        check_val("R10", "out_im in reset", longint'(out_im), 0);
        rst_n = 1'b1;
        idle.v = 1'b0; idle.re = 0; idle.im = 0; idle.tag = "R1";
        for (int k = 0; k < LAT; k++) q.push_back(idle);

        // R3 R4 R6 R9: x spectrum only, every bin
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++)
                step(1, r, c, 320000 + r * 1000, -160000 + c * 997, 0, 0, "R3 R4 R6 R9");

        // R3 R5 R6: y spectrum only, every bin
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++)
                step(1, r, c, 0, 0, -250000 + c * 1311, 170000 - r * 733, "R3 R5 R6");

        // R2: input tie rounding at (1,0), where the x factor is exactly j
        step(1, 1, 0, 24, -24, 0, 0, "R2");
        step(1, 1, 0, -23, 8, 0, 0, "R2");
        step(1, 1, 0, -8, 7, 0, 0, "R2");
        step(1, 1, 0, 40, -40, 0, 0, "R2");

        // R2 R8: full-scale inputs saturate at input and output
        step(1, 1, 0, 2097151, -2097152, 0, 0, "R2 R8");
        step(1, 1, 0, -2097152, 2097151, 0, 0, "R2 R8");
        step(1, 0, 1, 0, 0, 2097151, 2097151, "R2 R8");

        // R8: output ties at (1,1), where the factor is 8192 (one half)
        step(1, 1, 1, 48, 48, 0, 0, "R8");
        step(1, 1, 1, -48, -80, 0, 0, "R8");
        step(1, 1, 1, 16, -16, 0, 0, "R8");

        // R7: zero spectra
        step(1, 3, 5, 0, 0, 0, 0, "R7");
        step(1, 0, 0, 0, 0, 0, 0, "R7 R9");

        // R9: DC bin with large inputs
        step(1, 0, 0, 2000000, -1500000, 900000, -2097152, "R9");

        // R7 R11: both paths, random values, back to back
        for (int k = 0; k < 300; k++)
            step(1, int'($urandom % N), int'($urandom % N),
                 longint'(int'($urandom % 4194304) - 2097152),
                 longint'(int'($urandom % 4194304) - 2097152),
                 longint'(int'($urandom % 4194304) - 2097152),
                 longint'(int'($urandom % 4194304) - 2097152), "R6 R7 R11");

        // R1 R11: bins with idle gaps
        for (int k = 0; k < 60; k++)
            step(((k % 3) != 1), k % N, (k * 3) % N,
                 longint'(int'($urandom % 1048576) - 524288),
                 longint'(int'($urandom % 1048576) - 524288),
                 longint'(int'($urandom % 1048576) - 524288),
                 longint'(int'($urandom % 1048576) - 524288), "R1 R11");

        // flush
        for (int k = 0; k < LAT + 1; k++) step(0, 0, 0, 0, 0, 0, 0, "R1");

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule